// File: doc/BRIEF.md
# Receive Ping-Pong Buffer Controller

This block sits between a receive MAC front end and a shared frame memory. Frames arrive as a stream of words, each word qualified by `rx_valid`, with `rx_last` marking the final word. The block converts each accepted word into a write strobe and a word address inside one of two buffer windows: ping at `PING_BASE` and pong at `PONG_BASE`. With the default parameters, pong starts at word 0x600, which is byte offset 0x1800. Both windows are `BUF_WORDS` words long, and a frame is laid out the same way in either window.

Each buffer has an ownership flag. Hardware sets the flag when a frame has been completely stored in that buffer. Software clears it through a small register port once it has drained the buffer. Frames are assigned to buffers in strict alternation that restarts at ping after reset. If the buffer whose turn has come is still owned by software, the whole frame is discarded and the alternation does not move. A frame never spills from one buffer into the other. Words beyond `BUF_WORDS` are dropped and a truncation flag is recorded. A level interrupt reports completed frames when enabled. With `PINGPONG = 0` only the ping buffer exists.

The sequencer has four states:

- **IDLE**: waits for the first word of a frame.
  - Target buffer free: writes word 0. A single-word frame completes here; otherwise the sequencer moves to STORE.
  - Target buffer owned by software: moves to DROP, or stays in IDLE if that first word is also the last.
- **STORE**: writes words while room remains.
  - A last word completes the frame and returns to IDLE.
  - A word arriving when the buffer is full moves to TRUNC, or completes with the truncation flag if it is also the last word.
- **TRUNC**: discards words until the last word, then completes with the truncation flag and returns to IDLE.
- **DROP**: discards words until the last word, then returns to IDLE without completing.

Top module: `rxpp_ctrl`

## Requirements
- R1: After reset, both ownership flags, both truncation flags and the interrupt enable read 0, `irq` is low, and the first frame is written to ping.
- R2: Completed frames alternate ping, pong, ping and so on, in strict order from reset.
- R3: Word i of a frame is written at `PING_BASE + i` in ping or `PONG_BASE + i` in pong. The data on `mem_wdata` is the data presented on `rx_data` in the same cycle.
- R4: The clock edge that accepts a frame's last word sets that buffer's ownership flag, which reads as 1 from the next cycle onward.
- R5: Register select 0 is ping status and select 1 is pong status. Bit 0 of each is the ownership flag and bit 1 is the truncation flag. Writing with `reg_wbit = 0` clears both flags of that buffer. Writing with `reg_wbit = 1` leaves them unchanged. A flag falls only after such a clearing write.
- R6: A frame whose turn falls on a buffer still owned by software produces no memory write and no status change. The next frame goes to that same buffer.
- R7: Register select 2 bit 0 is the interrupt enable. `irq` is high exactly while the enable is 1 and at least one ownership flag is 1.
- R8: A frame longer than `BUF_WORDS` writes only its first `BUF_WORDS` words. On completion the truncation flag of that buffer reads 1.
- R9: With `PINGPONG = 0`, every frame goes to ping, pong status reads 0, and a frame that arrives while ping is owned is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | DATA_W | Receive word |
| rx_last | input | 1 | Marks the final word of a frame |
| mem_we | output | 1 | Frame memory write strobe |
| mem_addr | output | ADDR_W | Frame memory word address |
| mem_wdata | output | DATA_W | Frame memory write data |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 ping status, 1 pong status, 2 control |
| reg_wbit | input | 1 | Written value (status: 0 releases; control: interrupt enable) |
| reg_rdata | output | 2 | Read data of the selected register |
| irq | output | 1 | Receive-complete interrupt level |

## Verification
The main function is exercised with several frame patterns:

- Short frames into free buffers show whether the alternation and the base addresses are correct.
- A frame aimed at a still-owned buffer separates a design that drops the frame and holds its pointer from one that writes anyway or skips ahead.
- A frame longer than the buffer, and a single-word frame, exercise the full/truncate path and the IDLE-completion path.

A second instance built without pong checks that alternation is disabled there. Register writes with the keep value and the release value show that only a clearing write frees a buffer.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_TRUNC = 2'd2,
        ST_DROP  = 2'd3
    } rx_state_t;

    localparam logic [1:0] SEL_PING = 2'd0;
    localparam logic [1:0] SEL_PONG = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

endpackage

// File: rtl/rxpp_seq.sv
module rxpp_seq
    import rxpp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 11,
    parameter int BUF_WORDS = 512,
    parameter int PING_BASE = 'h000,
    parameter int PONG_BASE = 'h600,
    parameter bit PINGPONG  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    input  logic [1:0]        owned,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              fin,
    output logic              fin_buf,
    output logic              fin_trunc
);

    localparam int CNT_W = $clog2(BUF_WORDS + 1);
    localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(BUF_WORDS);
    localparam logic [ADDR_W-1:0] PING_A   = ADDR_W'(PING_BASE);
    localparam logic [ADDR_W-1:0] PONG_A   = ADDR_W'(PONG_BASE);

    rx_state_t        st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             turn_q;
    logic             tgt_busy;

    assign tgt_busy = owned[turn_q];

    // state register, word counter, alternation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    generate
        if (PINGPONG) begin : g_alt
            always_ff @(posedge clk) begin
                if (!rst_n)   turn_q <= 1'b0;
                else if (fin) turn_q <= ~turn_q;
            end
        end else begin : g_single
            assign turn_q = 1'b0;
        end
    endgenerate

    // next state and outputs
    always_comb begin
        st_nx     = st_q;
        cnt_nx    = cnt_q;
        mem_we    = 1'b0;
        fin       = 1'b0;
        fin_trunc = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (rx_valid) begin
                    if (!tgt_busy) begin
                        mem_we = 1'b1;
                        if (rx_last) begin
                            fin = 1'b1;
                        end else begin
                            st_nx  = ST_STORE;
                            cnt_nx = CNT_W'(1);
                        end
                    end else if (!rx_last) begin
                        st_nx = ST_DROP;
                    end
                end
            end
            ST_STORE: begin
                if (rx_valid) begin
                    if (cnt_q < CNT_MAX) begin
                        mem_we = 1'b1;
                        if (rx_last) begin
                            fin   = 1'b1;
                            st_nx = ST_IDLE;
                        end else begin
                            cnt_nx = cnt_q + CNT_W'(1);
                        end
                    end else if (rx_last) begin
                        fin       = 1'b1;
                        fin_trunc = 1'b1;
                        st_nx     = ST_IDLE;
                    end else begin
                        st_nx = ST_TRUNC;
                    end
                end
            end
            ST_TRUNC: begin
                if (rx_valid && rx_last) begin
                    fin       = 1'b1;
                    fin_trunc = 1'b1;
                    st_nx     = ST_IDLE;
                end
            end
            ST_DROP: begin
                if (rx_valid && rx_last) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
        if (st_nx == ST_IDLE) cnt_nx = '0;
    end

    assign fin_buf   = turn_q;
    assign mem_addr  = (turn_q ? PONG_A : PING_A) + ADDR_W'(cnt_q);
    assign mem_wdata = rx_data;

endmodule

// File: rtl/rxpp_regs.sv
module rxpp_regs
    import rxpp_pkg::*;
#(
    parameter bit PINGPONG = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fin,
    input  logic       fin_buf,
    input  logic       fin_trunc,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic       reg_wbit,
    output logic [1:0] reg_rdata,
    output logic [1:0] owned,
    output logic       irq_en,
    output logic       irq
);

    localparam int NBUF = PINGPONG ? 2 : 1;

    logic [1:0] trunc;

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_buf
            if (b < NBUF) begin : g_live
                logic hit_set, hit_clr;
                assign hit_set = fin && (fin_buf == b[0]);
                assign hit_clr = reg_wr && (reg_sel == 2'(b)) && !reg_wbit;
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        owned[b] <= 1'b0;
                        trunc[b] <= 1'b0;
                    end else if (hit_set) begin
                        owned[b] <= 1'b1;
                        trunc[b] <= fin_trunc;
                    end else if (hit_clr) begin
                        owned[b] <= 1'b0;
                        trunc[b] <= 1'b0;
                    end
                end
            end else begin : g_absent
                assign owned[b] = 1'b0;
                assign trunc[b] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)                            irq_en <= 1'b0;
        else if (reg_wr && reg_sel == SEL_CTRL) irq_en <= reg_wbit;
    end

    assign irq = irq_en && (owned != 2'b00);

    always_comb begin
        unique case (reg_sel)
            SEL_PING: reg_rdata = {trunc[0], owned[0]};
            SEL_PONG: reg_rdata = {trunc[1], owned[1]};
            SEL_CTRL: reg_rdata = {1'b0, irq_en};
            default:  reg_rdata = 2'b00;
        endcase
    end

endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl
    import rxpp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 11,
    parameter int BUF_WORDS = 512,
    parameter int PING_BASE = 'h000,
    parameter int PONG_BASE = 'h600,
    parameter bit PINGPONG  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wbit,
    output logic [1:0]        reg_rdata,
    output logic              irq
);

    logic [1:0] owned;
    logic       irq_en;
    logic       fin, fin_buf, fin_trunc;

    rxpp_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS),
        .PING_BASE(PING_BASE), .PONG_BASE(PONG_BASE), .PINGPONG(PINGPONG)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .owned(owned),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .fin(fin), .fin_buf(fin_buf), .fin_trunc(fin_trunc)
    );

    rxpp_regs #(
        .PINGPONG(PINGPONG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .fin(fin), .fin_buf(fin_buf), .fin_trunc(fin_trunc),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wbit(reg_wbit),
        .reg_rdata(reg_rdata), .owned(owned), .irq_en(irq_en), .irq(irq)
    );

endmodule

// File: rtl/rxpp_chk.sv
module rxpp_chk #(
    parameter int ADDR_W    = 11,
    parameter int BUF_WORDS = 512,
    parameter int PING_BASE = 'h000,
    parameter int PONG_BASE = 'h600,
    parameter bit PINGPONG  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        owned,
    input logic              irq_en,
    input logic              irq,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic              reg_wbit
);

    int  a_int;
    logic in_ping, in_pong;

    assign a_int   = int'({1'b0, mem_addr});
    assign in_ping = (a_int >= PING_BASE) && (a_int < PING_BASE + BUF_WORDS);
    assign in_pong = PINGPONG && (a_int >= PONG_BASE) && (a_int < PONG_BASE + BUF_WORDS);

    // R3
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (in_ping || in_pong));

    // R6
    ping_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && in_ping) |-> !owned[0]);

    // R6
    pong_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && in_pong) |-> !owned[1]);

    // R5
    ping_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(owned[0]) |-> $past(reg_wr && reg_sel == 2'd0 && !reg_wbit));

    // R5
    pong_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(owned[1]) |-> $past(reg_wr && reg_sel == 2'd1 && !reg_wbit));

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && $rose(owned[0])) |-> irq);

    generate
        if (!PINGPONG) begin : g_single
            // R9
            no_pong_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !owned[1] && !in_pong);
        end
    endgenerate

endmodule

bind rxpp_ctrl rxpp_chk #(
    .ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS),
    .PING_BASE(PING_BASE), .PONG_BASE(PONG_BASE), .PINGPONG(PINGPONG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .owned(owned), .irq_en(irq_en), .irq(irq),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wbit(reg_wbit)
);

// File: tb/sim_rxpp_ctrl.sv
module sim_rxpp_ctrl;

    localparam int CLK_P  = 10;
    localparam int DW     = 32;
    localparam int AW     = 11;
    localparam int BW     = 8;
    localparam int PONG_B = 'h600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic          v [2];
    logic [DW-1:0] d [2];
    logic          l [2];
    logic          rw [2];
    logic [1:0]    rs [2];
    logic          rb [2];
    logic          we [2];
    logic [AW-1:0] ad [2];
    logic [DW-1:0] wd [2];
    logic [1:0]    rd [2];
    logic          iq [2];

    rxpp_ctrl #(.DATA_W(DW), .ADDR_W(AW), .BUF_WORDS(BW),
                .PING_BASE(0), .PONG_BASE(PONG_B), .PINGPONG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(v[0]), .rx_data(d[0]), .rx_last(l[0]),
        .mem_we(we[0]), .mem_addr(ad[0]), .mem_wdata(wd[0]),
        .reg_wr(rw[0]), .reg_sel(rs[0]), .reg_wbit(rb[0]),
        .reg_rdata(rd[0]), .irq(iq[0]));

    rxpp_ctrl #(.DATA_W(DW), .ADDR_W(AW), .BUF_WORDS(BW),
                .PING_BASE(0), .PONG_BASE(PONG_B), .PINGPONG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .rx_valid(v[1]), .rx_data(d[1]), .rx_last(l[1]),
        .mem_we(we[1]), .mem_addr(ad[1]), .mem_wdata(wd[1]),
        .reg_wr(rw[1]), .reg_sel(rs[1]), .reg_wbit(rb[1]),
        .reg_rdata(rd[1]), .irq(iq[1]));

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [AW+DW-1:0] q0[$];
    logic [AW+DW-1:0] q1[$];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: presents one frame; base < 0 means the frame must be discarded
    task automatic send_frame(int inst, int n, int base, int id);
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0] w;
            @(negedge clk);
            w = {id[15:0], i[15:0]};
            v[inst] = 1'b1;
            d[inst] = w;
            l[inst] = (i == n - 1);
            if (base >= 0 && i < BW) begin
                if (inst == 0) q0.push_back({AW'(base + i), w});
                else           q1.push_back({AW'(base + i), w});
            end
        end
        @(negedge clk);
        v[inst] = 1'b0;
        l[inst] = 1'b0;
    endtask

    task automatic reg_write(int inst, logic [1:0] sel, logic bitv);
        @(negedge clk);
        rw[inst] = 1'b1;
        rs[inst] = sel;
        rb[inst] = bitv;
        @(negedge clk);
        rw[inst] = 1'b0;
    endtask

    task automatic reg_check(int inst, logic [1:0] sel, int exp, string req);
        rs[inst] = sel;
        #1;
        check(req, int'(rd[inst]), exp);
    endtask

    // monitors: pop expected writes and compare
    always begin
        @(negedge clk);
        #(CLK_P/4);
        for (int k = 0; k < 2; k++) begin
            if (rst_n && we[k]) begin
                logic [AW+DW-1:0] got;
                got = {ad[k], wd[k]};
                if ((k == 0 ? q0.size() : q1.size()) == 0) begin
                    checks++;
                    errs++;
                    $display("FAIL R6/R8 inst%0d: actual=%0h expected=no write", k, got);
                end else begin
                    logic [AW+DW-1:0] exp;
                    exp = (k == 0) ? q0.pop_front() : q1.pop_front();
                    check("R2/R3 write", int'(got[AW+DW-1:DW]), int'(exp[AW+DW-1:DW]));
                    check("R3 data", int'(got[DW-1:0]), int'(exp[DW-1:0]));
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            v[k] = 0; d[k] = '0; l[k] = 0; rw[k] = 0; rs[k] = 0; rb[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_check(0, 2'd0, 0, "R1 ping status");
        reg_check(0, 2'd1, 0, "R1 pong status");
        reg_check(0, 2'd2, 0, "R1 irq enable");
        check("R1 irq", int'(iq[0]), 0);

        reg_write(0, 2'd2, 1'b1);
        reg_check(0, 2'd2, 1, "R7 enable readback");

        // R1/R2 first frame to ping, R4 flag
        send_frame(0, 3, 0, 'hA);
        reg_check(0, 2'd0, 1, "R4 ping owned");
        check("R7 irq on", int'(iq[0]), 1);

        // R2 second frame to pong
        send_frame(0, 5, PONG_B, 'hB);
        reg_check(0, 2'd1, 1, "R4 pong owned");

        // R6 ping owned: frame discarded
        send_frame(0, 2, -1, 'hC);
        reg_check(0, 2'd0, 1, "R6 ping unchanged");
        reg_check(0, 2'd1, 1, "R6 pong unchanged");

        // R5 keep-write has no effect
        reg_write(0, 2'd0, 1'b1);
        reg_check(0, 2'd0, 1, "R5 keep write");

        // R5 release, R7 level follows flags
        reg_write(0, 2'd0, 1'b0);
        reg_check(0, 2'd0, 0, "R5 ping released");
        check("R7 irq pong held", int'(iq[0]), 1);
        reg_write(0, 2'd1, 1'b0);
        reg_check(0, 2'd1, 0, "R5 pong released");
        check("R7 irq off", int'(iq[0]), 0);

        // R6 pointer held: next frame still ping
        send_frame(0, 4, 0, 'hD);
        reg_check(0, 2'd0, 1, "R6 ping after drop");

        // R8 long frame into pong truncated
        send_frame(0, 11, PONG_B, 'hE);
        reg_check(0, 2'd1, 3, "R8 truncation flag");

        // R7 mask
        reg_write(0, 2'd2, 1'b0);
        check("R7 irq masked", int'(iq[0]), 0);

        // R5 release clears truncation, single-word frame to ping
        reg_write(0, 2'd0, 1'b0);
        reg_write(0, 2'd1, 1'b0);
        reg_check(0, 2'd1, 0, "R5 trunc cleared");
        send_frame(0, 1, 0, 'hF);
        reg_check(0, 2'd0, 1, "R4 single word");

        // R9 single-buffer instance
        send_frame(1, 2, 0, 'h1);
        reg_check(1, 2'd0, 1, "R9 ping owned");
        send_frame(1, 3, -1, 'h2);
        reg_check(1, 2'd1, 0, "R9 pong absent");
        reg_write(1, 2'd0, 1'b0);
        send_frame(1, 3, 0, 'h3);
        reg_check(1, 2'd0, 1, "R9 ping again");

        repeat (3) @(negedge clk);
        check("R3 inst0 queue drained", q0.size(), 0);
        check("R9 inst1 queue drained", q1.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule